// File: doc/BRIEF.md
# Sixteen-bit Down Counter/Timer with Square-Wave Output

This block is a down counter that is loaded from a preset register. Software writes the preset one byte at a time. It runs in one of two modes. In counter mode it counts the preset down once, raises a sticky ready flag when it reaches zero, and then parks at zero. In timer mode it reloads from the preset every time it passes zero and toggles a square-wave output at each reload. Counting advances only on clock-enable cycles (`tick`), so the pace of the count comes from a slower clock domain that the surrounding logic provides.

Software controls the block with three inputs: a start strobe, a stop strobe and a mode bit that is sampled at start. The live count can be read a byte at a time. Reading the top byte captures the lower bytes, so a multi-byte read stays consistent while the count keeps moving. The ready flag feeds an interrupt controller. In timer mode the flag marks one full period of the wave. A stop command clears the flag, but in timer mode it leaves the wave running.

The control machine has four states. ST_IDLE holds the count and is the state after reset or after a stop in counter mode. ST_CNT counts down once. ST_TC is parked at zero with ready set. ST_TMR is free-running.

The transitions are:
- Start moves any state to ST_CNT or ST_TMR, chosen by `mode_timer`.
- ST_CNT moves to ST_TC on the tick that brings the count to zero.
- ST_CNT and ST_TC return to ST_IDLE on stop.
- ST_TMR leaves only on a new start.

Top module: `cnt_timer`

## Requirements
- R1: Writing with `wr_en` high stores `wr_data` into the preset byte chosen by `wr_sel`: 1 selects bits 15:8 and 0 selects bits 7:0. The full preset is what a later start loads.
- R2: After reset the block is idle, `count_val` is 0, `ready` is 0 and `sq_out` is 0.
- R3: A start loads the preset into the count on the next clock edge. After that the count drops by one on each edge where `tick` is high, and it does not change on any edge where `tick` is low.
- R4: In counter mode, the tick that brings the count to zero sets `ready`. The count then stays at 0 through further ticks until the next start.
- R5: In counter mode, a stop clears `ready` and freezes the count at its current value. Later ticks do not move it.
- R6: In timer mode, a tick while the count is 0 reloads the preset and inverts `sq_out`, so each half period lasts preset+1 ticks. Outside timer mode, `sq_out` is 0.
- R7: In timer mode, `ready` is set only on the reload where `sq_out` goes from 1 to 0. This happens once per full wave period, on every second pass through zero.
- R8: In timer mode, a stop clears `ready` but leaves counting, reloading and the wave running. A stop wins over a ready-set in the same cycle.
- R9: A read with `rd_en` high and `rd_sel`=1 returns count bits 15:8 and captures bits 7:0 at that edge. A later read with `rd_sel`=0 returns the captured byte, even after the count has moved.
- R10: Start wins over stop in the same cycle. A start clears `ready` and `sq_out`, and it restarts from any state.
- R11: A preset write while the timer runs does not change the count in progress. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one cycle per count step |
| mode_timer | input | 1 | Mode sampled at start: 1 timer, 0 counter |
| cmd_start | input | 1 | Start strobe |
| cmd_stop | input | 1 | Stop strobe |
| wr_en | input | 1 | Preset byte write enable |
| wr_sel | input | 1 | Preset byte select (1 upper, 0 lower) |
| wr_data | input | 8 | Preset byte data |
| rd_en | input | 1 | Read strobe; with rd_sel=1 captures lower byte |
| rd_sel | input | 1 | Read byte select (1 upper live, 0 lower captured) |
| rd_data | output | 8 | Selected count byte |
| count_val | output | 16 | Live count |
| sq_out | output | 1 | Square-wave output |
| ready | output | 1 | Sticky ready flag |

## Verification
The counter mode is driven with a small preset counted through zero and on past it, which separates stopping at terminal count from wrapping around. A larger preset is stopped mid-count, which separates halting from clearing. The timer mode is driven with preset 2 and watched over two full periods, with and without a stop in between. This tells a ready flag that fires on every zero apart from one that fires on every second zero, and shows whether a stop halts the wave. Other sequences cover a preset rewrite in the middle of a period, a start and stop arriving together, and a byte read taken in the same cycle as a tick.

// File: rtl/cnt_timer_pkg.sv
`timescale 1ns/1ps
package cnt_timer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CNT  = 2'd1,
        ST_TC   = 2'd2,
        ST_TMR  = 2'd3
    } ctmr_state_e;
endpackage

// File: rtl/cnt_timer_preset.sv
`timescale 1ns/1ps
module cnt_timer_preset #(
    parameter int W      = 16,
    parameter int BYTE_W = 8,
    localparam int NBYTES = W / BYTE_W,
    localparam int SEL_W  = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [W-1:0]      preset
);
    // One byte lane per preset slice
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                preset[g*BYTE_W +: BYTE_W] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                preset[g*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/cnt_timer_rdlatch.sv
`timescale 1ns/1ps
module cnt_timer_rdlatch #(
    parameter int W      = 16,
    parameter int BYTE_W = 8,
    localparam int NBYTES = W / BYTE_W,
    localparam int SEL_W  = $clog2(NBYTES),
    localparam int LW     = W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [W-1:0]      count,
    output logic [BYTE_W-1:0] rd_data
);
    localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(NBYTES - 1);

    logic [LW-1:0]     lat_q;
    logic [BYTE_W-1:0] view [NBYTES];

    // Reading the top byte freezes the lower bytes for the rest of the read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (rd_en && (rd_sel == TOP_SEL)) begin
            lat_q <= count[LW-1:0];
        end
    end

    for (genvar g = 0; g < NBYTES - 1; g++) begin : g_view
        assign view[g] = lat_q[g*BYTE_W +: BYTE_W];
    end
    assign view[NBYTES-1] = count[W-1 -: BYTE_W];

    assign rd_data = view[rd_sel];
endmodule

// File: rtl/cnt_timer_core.sv
`timescale 1ns/1ps
module cnt_timer_core
    import cnt_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         mode_timer,
    input  logic         cmd_start,
    input  logic         cmd_stop,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count_q,
    output logic         sq_q,
    output logic         ready_q
);
    ctmr_state_e state_q, state_d;
    logic        last_step;

    assign last_step = (count_q <= W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (cmd_start) begin
            state_d = mode_timer ? ST_TMR : ST_CNT;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_CNT: begin
                    if (cmd_stop)               state_d = ST_IDLE;
                    else if (tick && last_step) state_d = ST_TC;
                end
                ST_TC:  if (cmd_stop) state_d = ST_IDLE;
                ST_TMR: state_d = ST_TMR;
            endcase
        end
    end

    // Count, wave and flag outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            sq_q    <= 1'b0;
            ready_q <= 1'b0;
        end else if (cmd_start) begin
            count_q <= preset;
            sq_q    <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            if (cmd_stop) ready_q <= 1'b0;
            unique case (state_q)
                ST_CNT: begin
                    if (!cmd_stop && tick) begin
                        if (last_step) begin
                            count_q <= '0;
                            ready_q <= 1'b1;
                        end else begin
                            count_q <= count_q - W'(1);
                        end
                    end
                end
                ST_TMR: begin
                    if (tick) begin
                        if (count_q == '0) begin
                            count_q <= preset;
                            sq_q    <= ~sq_q;
                            if (sq_q && !cmd_stop) ready_q <= 1'b1;
                        end else begin
                            count_q <= count_q - W'(1);
                        end
                    end
                end
                ST_IDLE, ST_TC: ;
            endcase
        end
    end

    // Checks next to the logic they guard
    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cmd_start) |=> $stable(count_q));

    assert_tc_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TC && !cmd_start) |=> (count_q == '0));

    assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_start) |=> !ready_q);

    assert_cnt_stop_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CNT && cmd_stop && !cmd_start) |=> ($stable(count_q) && state_q == ST_IDLE));

    assert_sq_low_outside_timer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_TMR) |-> !sq_q);

    assert_ready_on_falling_wave_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready_q) && state_q == ST_TMR) |-> $fell(sq_q));

    assert_timer_keeps_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TMR && !cmd_start) |=> (state_q == ST_TMR));
endmodule

// File: rtl/cnt_timer.sv
`timescale 1ns/1ps
module cnt_timer #(
    parameter int W      = 16,
    parameter int BYTE_W = 8,
    localparam int NBYTES = W / BYTE_W,
    localparam int SEL_W  = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              mode_timer,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic [W-1:0]      count_val,
    output logic              sq_out,
    output logic              ready
);
    logic [W-1:0] preset;

    cnt_timer_preset #(.W(W), .BYTE_W(BYTE_W)) u_preset (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .preset(preset)
    );

    cnt_timer_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_timer(mode_timer),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .preset(preset),
        .count_q(count_val), .sq_q(sq_out), .ready_q(ready)
    );

    cnt_timer_rdlatch #(.W(W), .BYTE_W(BYTE_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel),
        .count(count_val), .rd_data(rd_data)
    );
endmodule

// File: tb/cnt_timer_tb.sv
`timescale 1ns/1ps
module cnt_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, mode_timer = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [0:0]  wr_sel = 1'b0, rd_sel = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic [15:0] count_val;
    logic        sq_out, ready;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    cnt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_timer(mode_timer),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .count_val(count_val), .sq_out(sq_out), .ready(ready)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_preset(logic [15:0] v);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = v[15:8];
        @(negedge clk);
        wr_sel = 1'b0; wr_data = v[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start(logic tmr);
        mode_timer = tmr; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic stop();
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
    endtask

    task automatic ticks(int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R2 count", int'(count_val), 0);
        chk("R2 ready", int'(ready), 0);
        chk("R2 sq", int'(sq_out), 0);
    endtask

    task automatic t_counter_tc();
        write_preset(16'h0005);
        start(1'b0);
        chk("R1 load", int'(count_val), 5);
        repeat (4) @(negedge clk);
        chk("R3 no tick", int'(count_val), 5);
        ticks(3);
        chk("R3 decrement", int'(count_val), 2);
        chk("R4 not yet", int'(ready), 0);
        ticks(2);
        chk("R4 tc count", int'(count_val), 0);
        chk("R4 tc ready", int'(ready), 1);
        ticks(3);
        chk("R4 parked", int'(count_val), 0);
        chk("R4 sticky", int'(ready), 1);
        chk("R6 sq low counter", int'(sq_out), 0);
        stop();
        chk("R5 stop clears", int'(ready), 0);
    endtask

    task automatic t_counter_stop();
        write_preset(16'h0100);
        start(1'b0);
        ticks(4);
        chk("R3 borrow", int'(count_val), 16'h00FC);
        stop();
        ticks(5);
        chk("R5 halted", int'(count_val), 16'h00FC);
        chk("R5 no ready", int'(ready), 0);
    endtask

    task automatic t_timer_wave();
        write_preset(16'h0002);
        start(1'b1);
        chk("R6 start sq", int'(sq_out), 0);
        ticks(2);
        chk("R6 reach zero", int'(count_val), 0);
        ticks(1);
        chk("R6 reload", int'(count_val), 2);
        chk("R6 toggle hi", int'(sq_out), 1);
        chk("R7 no ready first zero", int'(ready), 0);
        ticks(3);
        chk("R6 toggle lo", int'(sq_out), 0);
        chk("R7 ready second zero", int'(ready), 1);
    endtask

    task automatic t_timer_stop();
        write_preset(16'h0002);
        start(1'b1);
        ticks(6);
        chk("R7 period ready", int'(ready), 1);
        stop();
        chk("R8 stop clears", int'(ready), 0);
        chk("R8 count kept", int'(count_val), 2);
        ticks(3);
        chk("R8 still toggling", int'(sq_out), 1);
        chk("R8 ready stays clear", int'(ready), 0);
        ticks(3);
        chk("R8 next period ready", int'(ready), 1);
    endtask

    task automatic t_preset_live();
        write_preset(16'h0002);
        start(1'b1);
        ticks(1);
        write_preset(16'h0004);
        chk("R11 count untouched", int'(count_val), 1);
        ticks(1);
        chk("R11 reaches zero", int'(count_val), 0);
        ticks(1);
        chk("R11 new reload", int'(count_val), 4);
        chk("R11 sq toggled", int'(sq_out), 1);
    endtask

    task automatic t_start_priority();
        write_preset(16'h0003);
        start(1'b0);
        ticks(3);
        chk("R4 ready before restart", int'(ready), 1);
        cmd_stop = 1'b1;
        start(1'b0);
        cmd_stop = 1'b0;
        chk("R10 reloaded", int'(count_val), 3);
        chk("R10 ready cleared", int'(ready), 0);
        ticks(1);
        chk("R10 keeps counting", int'(count_val), 2);
        write_preset(16'h0000);
        start(1'b1);
        ticks(1);
        chk("R6 zero preset toggles", int'(sq_out), 1);
        start(1'b1);
        chk("R10 sq cleared", int'(sq_out), 0);
    endtask

    task automatic t_read();
        write_preset(16'h12FF);
        start(1'b0);
        ticks(1);
        chk("R3 read setup", int'(count_val), 16'h12FE);
        rd_en = 1'b1; rd_sel = 1'b1; tick = 1'b1;
        #1;
        chk("R9 upper byte", int'(rd_data), 8'h12);
        @(negedge clk);
        rd_en = 1'b0; rd_sel = 1'b0; tick = 1'b0;
        #1;
        chk("R9 captured lower", int'(rd_data), 8'hFE);
        chk("R9 live moved", int'(count_val), 16'h12FD);
        ticks(2);
        #1;
        chk("R9 capture held", int'(rd_data), 8'hFE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counter_tc();
        t_counter_stop();
        t_timer_wave();
        t_timer_stop();
        t_preset_live();
        t_start_priority();
        t_read();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule